// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block produces, one by one, every configuration frame address of a column-organised programmable-logic array. A loader streams frame payload behind it. Before a walk, a column table is written through a simple write port. Each entry holds a 3-bit type code for one main-area column, counted from the left. Three geometry inputs give the number of columns and the number of regions in the top and bottom halves. These inputs are captured when a walk starts.

A one-cycle `start` pulse launches the walk. Addresses come out on a valid/ready stream. Each address carries a frame type, a half, a region, a major number and a minor number. The final address also carries `fa_last`.

Back-pressure rules:
- A beat transfers on a rising edge where `fa_valid` and `fa_ready` are both high.
- While `fa_valid` is high and `fa_ready` is low, the valid signal and the whole payload hold unchanged.
- `fa_ready` may toggle freely and has no effect while `fa_valid` is low.
- The block never retracts an offered address.

Walk order:
1. Frame type: the main area first, then the RAM-content area.
2. Half: top first, then bottom.
3. Region: from 0 upward, counted outward from the configuration tile.
4. Major number.
5. Minor number, which changes fastest.

Top module: `cfg_frame_walker`

## Requirements
- R1: After reset, `busy`, `fa_valid`, `fa_last` and `done` are all low.
- R2: Addresses come out in this nesting order, outermost first:
  - frame type `fa_type` (0 = main area, then 1 = RAM content);
  - half `fa_half` (0 = top, then 1 = bottom);
  - region, ascending from 0;
  - major number;
  - minor number, ascending from 0.
- R3: In the main area, the major number equals the table index, and every column is visited. The number of minors follows the column's type code:

  | Code | Minors |
  |------|--------|
  | 0, 1 | 36 |
  | 2, 3 | 30 |
  | 4 | 28 |
  | 5 | 54 |
  | 6 | 32 |
  | 7 | 4 |

- R4: In the RAM-content area, only columns coded 2 or 3 are visited.
  - Each such column gets 128 minors.
  - Major numbers count these columns from 0, starting at the leftmost.
  - If no such column exists, the RAM-content area is skipped entirely.
- R5: Each half visits regions 0 to N-1. N is `top_regions` for the top half and `bot_regions` for the bottom half.
- R6: While `fa_valid` is high and `fa_ready` is low, `fa_valid` stays high and every payload field holds its value on the next cycle.
- R7: `fa_last` is high only with the final address. The total number of transferred beats equals the sum, over all visited columns and regions, of their minor counts.
- R8: `done` pulses high for exactly one cycle, on the cycle after the final beat transfers. At the same time `busy` drops and `fa_valid` is low.
- R9: A `start` pulse while `busy` is high is ignored. The running walk continues unchanged.
- R10: Table writes while `busy` is high are ignored. Writes made while idle take effect on the next walk.
- R11: After `start` is sampled by a rising edge while idle, `fa_valid` rises on the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Column table write strobe |
| cfg_wr_idx | input | COL_AW (6) | Table entry to write |
| cfg_wr_code | input | 3 | Column type code to store |
| col_count | input | COL_AW+1 (7) | Number of main-area columns (1..MAX_COLS), captured at start |
| top_regions | input | REG_W (5) | Regions in the top half (>=1), captured at start |
| bot_regions | input | REG_W (5) | Regions in the bottom half (>=1), captured at start |
| start | input | 1 | One-cycle walk launch pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the final beat |
| fa_valid | output | 1 | Address offered |
| fa_ready | input | 1 | Consumer accepts the address |
| fa_type | output | 1 | Frame type: 0 main, 1 RAM content |
| fa_half | output | 1 | 0 top, 1 bottom |
| fa_region | output | REG_W (5) | Region within the half |
| fa_major | output | COL_AW (6) | Major number |
| fa_minor | output | 7 | Minor number |
| fa_last | output | 1 | Final address of the walk |

## Verification
The first address is offered exactly two rising edges after `start` is driven: one edge captures the geometry and one resolves the first column. The bench therefore samples `fa_valid` low at the falling edge after the capturing edge and high at the next falling edge.

A beat counts on the rising edge where valid and ready are both high. The bench samples at the falling edge before that edge and compares the payload against its own model in the same sample. A stalled offer is compared against the payload seen at the previous falling edge.

`done` is due one edge after the final beat. It is accepted only when the previous falling-edge sample showed a handshake carrying `fa_last`.

// File: rtl/fwalk_pkg.sv
`timescale 1ns/1ps
package fwalk_pkg;

  typedef logic [2:0] col_code_t;

  localparam int MINOR_W = 7;

  localparam col_code_t COL_LOGIC_A = 3'd0;
  localparam col_code_t COL_LOGIC_B = 3'd1;
  localparam col_code_t COL_MEM     = 3'd2;
  localparam col_code_t COL_HARD    = 3'd3;
  localparam col_code_t COL_ARITH   = 3'd4;
  localparam col_code_t COL_PAD     = 3'd5;
  localparam col_code_t COL_SERDES  = 3'd6;
  localparam col_code_t COL_SPINE   = 3'd7;

  localparam logic [MINOR_W-1:0] MEM_LAST_MINOR = 7'd127;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_SCAN = 2'd1,
    W_EMIT = 2'd2
  } walk_state_t;

  // Index of the final minor frame of a main-area column of the given type.
  function automatic logic [MINOR_W-1:0] main_last_minor(input col_code_t code);
    case (code)
      COL_LOGIC_A, COL_LOGIC_B: main_last_minor = 7'd35;
      COL_MEM, COL_HARD:        main_last_minor = 7'd29;
      COL_ARITH:                main_last_minor = 7'd27;
      COL_PAD:                  main_last_minor = 7'd53;
      COL_SERDES:               main_last_minor = 7'd31;
      default:                  main_last_minor = 7'd3;
    endcase
  endfunction

  function automatic logic holds_mem(input col_code_t code);
    holds_mem = (code == COL_MEM) || (code == COL_HARD);
  endfunction

endpackage

// File: rtl/fwalk_coltab.sv
`timescale 1ns/1ps
module fwalk_coltab
  import fwalk_pkg::*;
#(
  parameter int MAX_COLS = 64,
  parameter int COL_AW   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [COL_AW-1:0]            wr_idx,
  input  col_code_t                    wr_code,
  input  logic                         busy,
  input  logic [COL_AW-1:0]            rd_idx,
  output col_code_t                    rd_code,
  output logic [MAX_COLS-1:0][2:0]     tab_o
);

  logic [MAX_COLS-1:0][2:0] tab_q;

  for (genvar g = 0; g < MAX_COLS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[g] <= COL_LOGIC_A;
      end else if (wr_en && !busy && (wr_idx == COL_AW'(g))) begin
        tab_q[g] <= wr_code;
      end
    end
  end

  assign rd_code = tab_q[rd_idx];
  assign tab_o   = tab_q;

  // R10: the table is frozen while a walk runs
  p_table_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (tab_q == $past(tab_q)));

endmodule

// File: rtl/fwalk_memfind.sv
`timescale 1ns/1ps
module fwalk_memfind
  import fwalk_pkg::*;
#(
  parameter int MAX_COLS = 64,
  parameter int COL_AW   = 6
) (
  input  logic [MAX_COLS-1:0][2:0] tab,
  input  logic [COL_AW:0]          ncols,
  output logic                     any_mem,
  output logic [COL_AW-1:0]        last_mem
);

  // Rightmost in-range column holding RAM content, used to mark the final frame.
  always_comb begin
    any_mem  = 1'b0;
    last_mem = '0;
    for (int i = 0; i < MAX_COLS; i++) begin
      if ((i < int'(ncols)) && holds_mem(tab[i])) begin
        any_mem  = 1'b1;
        last_mem = COL_AW'(i);
      end
    end
  end

endmodule

// File: rtl/fwalk_seq.sv
`timescale 1ns/1ps
module fwalk_seq
  import fwalk_pkg::*;
#(
  parameter int COL_AW = 6,
  parameter int REG_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COL_AW:0]    ncols_in,
  input  logic [REG_W-1:0]   ntop_in,
  input  logic [REG_W-1:0]   nbot_in,
  input  col_code_t          col_code,
  input  logic               any_mem,
  input  logic [COL_AW-1:0]  last_mem,
  input  logic               out_ready,
  output logic               busy,
  output logic [COL_AW:0]    ncols_o,
  output logic [COL_AW-1:0]  col_idx,
  output logic               out_valid,
  output logic               out_type,
  output logic               out_half,
  output logic [REG_W-1:0]   out_region,
  output logic [COL_AW-1:0]  out_major,
  output logic [MINOR_W-1:0] out_minor,
  output logic               out_last,
  output logic               done
);

  localparam logic [COL_AW:0]   CNT_ONE = 1;
  localparam logic [COL_AW-1:0] IDX_ONE = 1;
  localparam logic [REG_W-1:0]  REG_ONE = 1;

  walk_state_t          state_q;
  logic                 ftype_q, half_q, done_q;
  logic [REG_W-1:0]     region_q, ntop_q, nbot_q;
  logic [COL_AW:0]      ncols_q;
  logic [COL_AW-1:0]    col_q, mem_maj_q;
  logic [MINOR_W-1:0]   minor_q;

  logic [MINOR_W-1:0]   minor_end;
  logic [REG_W-1:0]     reg_lim;
  logic                 col_end, row_end, frame_end, is_final, emit;
  logic                 nx_ftype, nx_half;
  logic [REG_W-1:0]     nx_region;
  logic [COL_AW-1:0]    nx_col, nx_mem_maj;

  always_comb begin
    minor_end  = ftype_q ? MEM_LAST_MINOR : main_last_minor(col_code);
    reg_lim    = half_q ? nbot_q : ntop_q;
    col_end    = ({1'b0, col_q} == (ncols_q - CNT_ONE));
    row_end    = col_end && (region_q == (reg_lim - REG_ONE));
    frame_end  = (minor_q == minor_end);
    nx_col     = col_end ? '0 : (col_q + IDX_ONE);
    nx_mem_maj = col_end ? '0 :
                 (mem_maj_q + ((ftype_q && holds_mem(col_code)) ? IDX_ONE : '0));
    nx_region  = !col_end ? region_q : (row_end ? '0 : (region_q + REG_ONE));
    nx_half    = row_end ? ~half_q : half_q;
    nx_ftype   = (row_end && half_q) ? 1'b1 : ftype_q;
    is_final   = (ftype_q == any_mem) && half_q &&
                 (region_q == (nbot_q - REG_ONE)) && frame_end &&
                 (any_mem ? (col_q == last_mem) : col_end);
    emit       = (state_q == W_EMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      ftype_q   <= 1'b0;
      half_q    <= 1'b0;
      region_q  <= '0;
      ntop_q    <= '0;
      nbot_q    <= '0;
      ncols_q   <= '0;
      col_q     <= '0;
      mem_maj_q <= '0;
      minor_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        W_IDLE: begin
          if (start) begin
            ncols_q   <= ncols_in;
            ntop_q    <= ntop_in;
            nbot_q    <= nbot_in;
            ftype_q   <= 1'b0;
            half_q    <= 1'b0;
            region_q  <= '0;
            col_q     <= '0;
            mem_maj_q <= '0;
            minor_q   <= '0;
            state_q   <= W_SCAN;
          end
        end
        W_SCAN: begin
          if (!ftype_q || holds_mem(col_code)) begin
            state_q <= W_EMIT;
          end else begin
            col_q     <= nx_col;
            mem_maj_q <= nx_mem_maj;
            region_q  <= nx_region;
            half_q    <= nx_half;
            ftype_q   <= nx_ftype;
          end
        end
        W_EMIT: begin
          if (out_ready) begin
            if (is_final) begin
              state_q <= W_IDLE;
              done_q  <= 1'b1;
            end else if (frame_end) begin
              minor_q   <= '0;
              col_q     <= nx_col;
              mem_maj_q <= nx_mem_maj;
              region_q  <= nx_region;
              half_q    <= nx_half;
              ftype_q   <= nx_ftype;
              state_q   <= W_SCAN;
            end else begin
              minor_q <= minor_q + 1'b1;
            end
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != W_IDLE);
  assign ncols_o    = ncols_q;
  assign col_idx    = col_q;
  assign out_valid  = emit;
  assign out_type   = ftype_q;
  assign out_half   = half_q;
  assign out_region = region_q;
  assign out_major  = ftype_q ? mem_maj_q : col_q;
  assign out_minor  = minor_q;
  assign out_last   = emit && is_final;
  assign done       = done_q;

  // R3: the minor counter never passes the column's frame count
  p_minor_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (minor_q <= minor_end));

  // R4: RAM-content frames only come from RAM or hard-logic columns
  p_mem_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && ftype_q) |-> holds_mem(col_code));

  // R5: the region stays within the programmed count of its half
  p_region_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (region_q < reg_lim));

  // R9: a start during a walk leaves the captured geometry untouched
  p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ncols_q) && $stable(ntop_q) && $stable(nbot_q)));

endmodule

// File: rtl/cfg_frame_walker.sv
`timescale 1ns/1ps
module cfg_frame_walker
  import fwalk_pkg::*;
#(
  parameter  int MAX_COLS = 64,
  parameter  int REG_W    = 5,
  localparam int COL_AW   = $clog2(MAX_COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [COL_AW-1:0]  cfg_wr_idx,
  input  logic [2:0]         cfg_wr_code,
  input  logic [COL_AW:0]    col_count,
  input  logic [REG_W-1:0]   top_regions,
  input  logic [REG_W-1:0]   bot_regions,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               fa_valid,
  input  logic               fa_ready,
  output logic               fa_type,
  output logic               fa_half,
  output logic [REG_W-1:0]   fa_region,
  output logic [COL_AW-1:0]  fa_major,
  output logic [6:0]         fa_minor,
  output logic               fa_last
);

  logic [MAX_COLS-1:0][2:0] tab;
  col_code_t                cur_code;
  logic [COL_AW-1:0]        cur_idx;
  logic [COL_AW:0]          ncols_q;
  logic                     any_mem;
  logic [COL_AW-1:0]        last_mem;

  fwalk_coltab #(.MAX_COLS(MAX_COLS), .COL_AW(COL_AW)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_idx),
    .wr_code (cfg_wr_code),
    .busy    (busy),
    .rd_idx  (cur_idx),
    .rd_code (cur_code),
    .tab_o   (tab)
  );

  fwalk_memfind #(.MAX_COLS(MAX_COLS), .COL_AW(COL_AW)) u_find (
    .tab      (tab),
    .ncols    (ncols_q),
    .any_mem  (any_mem),
    .last_mem (last_mem)
  );

  fwalk_seq #(.COL_AW(COL_AW), .REG_W(REG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ncols_in   (col_count),
    .ntop_in    (top_regions),
    .nbot_in    (bot_regions),
    .col_code   (cur_code),
    .any_mem    (any_mem),
    .last_mem   (last_mem),
    .out_ready  (fa_ready),
    .busy       (busy),
    .ncols_o    (ncols_q),
    .col_idx    (cur_idx),
    .out_valid  (fa_valid),
    .out_type   (fa_type),
    .out_half   (fa_half),
    .out_region (fa_region),
    .out_major  (fa_major),
    .out_minor  (fa_minor),
    .out_last   (fa_last),
    .done       (done)
  );

  // R6: a stalled offer holds valid and payload
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_valid && !fa_ready) |=> (fa_valid && $stable(fa_type) && $stable(fa_half) &&
                                 $stable(fa_region) && $stable(fa_major) &&
                                 $stable(fa_minor) && $stable(fa_last)));

  // R7: last only accompanies an offered address
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fa_last |-> fa_valid);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the final beat is followed by done with the walk closed
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_valid && fa_ready && fa_last) |=> (done && !busy && !fa_valid));

endmodule

// File: tb/cfg_frame_walker_tb.sv
`timescale 1ns/1ps
module cfg_frame_walker_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [5:0] cfg_wr_idx = '0;
  logic [2:0] cfg_wr_code = '0;
  logic [6:0] col_count = 7'd1;
  logic [4:0] top_regions = 5'd1;
  logic [4:0] bot_regions = 5'd1;
  logic       start = 1'b0;
  logic       busy, done, fa_valid, fa_type, fa_half, fa_last;
  logic       fa_ready = 1'b1;
  logic [4:0] fa_region;
  logic [5:0] fa_major;
  logic [6:0] fa_minor;

  cfg_frame_walker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_code(cfg_wr_code), .col_count(col_count), .top_regions(top_regions),
    .bot_regions(bot_regions), .start(start), .busy(busy), .done(done),
    .fa_valid(fa_valid), .fa_ready(fa_ready), .fa_type(fa_type), .fa_half(fa_half),
    .fa_region(fa_region), .fa_major(fa_major), .fa_minor(fa_minor), .fa_last(fa_last)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  int tb_tab [64];
  int tb_ncols, tb_ntop, tb_nbot;
  logic [19:0] exp_q [$];

  bit          mon_en = 1'b0;
  int          got, n_main, n_mem, max_top, max_bot, done_cnt;
  bit          stall_prev, last_prev;
  logic [20:0] stall_word;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  function automatic int minors_of(input int code);
    case (code)
      0, 1:    return 36;
      2, 3:    return 30;
      4:       return 28;
      5:       return 54;
      6:       return 32;
      default: return 4;
    endcase
  endfunction

  task automatic build_model();
    exp_q.delete();
    for (int t = 0; t < 2; t++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < (h ? tb_nbot : tb_ntop); r++) begin
          int mm = 0;
          for (int c = 0; c < tb_ncols; c++) begin
            bit mem = (tb_tab[c] == 2) || (tb_tab[c] == 3);
            if (t == 0) begin
              for (int m = 0; m < minors_of(tb_tab[c]); m++)
                exp_q.push_back({1'b0, h[0], r[4:0], c[5:0], m[6:0]});
            end else if (mem) begin
              for (int m = 0; m < 128; m++)
                exp_q.push_back({1'b1, h[0], r[4:0], mm[5:0], m[6:0]});
              mm++;
            end
          end
        end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [20:0] cur;
      cur = {fa_type, fa_half, fa_region, fa_major, fa_minor, fa_last};
      if (stall_prev)
        check(fa_valid && (cur == stall_word), "R6",
              $sformatf("stalled offer changed: got %h exp %h valid=%0b", cur, stall_word, fa_valid));
      stall_prev = fa_valid && !fa_ready;
      stall_word = cur;
      if (done) begin
        check(last_prev && !busy && !fa_valid, "R8",
              $sformatf("done: prev_last=%0b busy=%0b valid=%0b exp 1/0/0", last_prev, busy, fa_valid));
        done_cnt++;
      end
      last_prev = 1'b0;
      if (fa_valid && fa_ready) begin
        if (got < exp_q.size()) begin
          check(cur[20:1] == exp_q[got], "R2/R3/R4/R5",
                $sformatf("beat %0d: got %h exp %h", got, cur[20:1], exp_q[got]));
          check(fa_last == (got == exp_q.size() - 1), "R7",
                $sformatf("beat %0d last: got %0b exp %0b", got, fa_last, got == exp_q.size() - 1));
        end else begin
          check(1'b0, "R7", $sformatf("extra beat %0d: got %h exp none", got, cur[20:1]));
        end
        if (fa_type) n_mem++; else n_main++;
        if (!fa_half && int'(fa_region) > max_top) max_top = int'(fa_region);
        if (fa_half && int'(fa_region) > max_bot) max_bot = int'(fa_region);
        last_prev = fa_last;
        got++;
      end
    end
  end

  task automatic load_table();
    for (int i = 0; i < tb_ncols; i++) begin
      @(posedge clk); #1;
      cfg_wr_en = 1'b1; cfg_wr_idx = 6'(i); cfg_wr_code = 3'(tb_tab[i]);
    end
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    col_count = 7'(tb_ncols); top_regions = 5'(tb_ntop); bot_regions = 5'(tb_nbot);
  endtask

  task automatic run_walk(input string name, input bit bp, input bit poke,
                          input int exp_total, input int exp_main, input int exp_mem);
    int cyc;
    build_model();
    check(exp_q.size() == exp_total, "R7",
          $sformatf("%s model size: got %0d exp %0d", name, exp_q.size(), exp_total));
    got = 0; n_main = 0; n_mem = 0; max_top = -1; max_bot = -1; done_cnt = 0;
    stall_prev = 1'b0; last_prev = 1'b0;
    mon_en = 1'b1;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(!fa_valid, "R11", $sformatf("%s valid one edge after start: got %0b exp 0", name, fa_valid));
    @(negedge clk);
    check(fa_valid, "R11", $sformatf("%s valid two edges after start: got %0b exp 1", name, fa_valid));
    cyc = 0;
    while (done_cnt == 0 && cyc < 30000) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fa_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      start = poke && (cyc == 40);          // R9 stimulus
      if (poke && cyc == 60) begin          // R10 stimulus
        cfg_wr_en = 1'b1; cfg_wr_idx = 6'd0; cfg_wr_code = 3'd5;
      end else begin
        cfg_wr_en = 1'b0;
      end
      cyc++;
    end
    start = 1'b0; cfg_wr_en = 1'b0; fa_ready = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    check(done_cnt == 1, "R8", $sformatf("%s done pulses: got %0d exp 1", name, done_cnt));
    check(got == exp_total, "R7", $sformatf("%s beats: got %0d exp %0d", name, got, exp_total));
    check(n_main == exp_main, "R3", $sformatf("%s main beats: got %0d exp %0d", name, n_main, exp_main));
    check(n_mem == exp_mem, "R4", $sformatf("%s RAM beats: got %0d exp %0d", name, n_mem, exp_mem));
    check(max_top == tb_ntop - 1 && max_bot == tb_nbot - 1, "R5",
          $sformatf("%s top/bottom max region: got %0d/%0d exp %0d/%0d",
                    name, max_top, max_bot, tb_ntop - 1, tb_nbot - 1));
    check(!busy && !fa_valid && !done, "R8",
          $sformatf("%s idle after walk: busy=%0b valid=%0b done=%0b exp 0", name, busy, fa_valid, done));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !fa_valid && !fa_last && !done, "R1",
          $sformatf("reset: busy=%0b valid=%0b last=%0b done=%0b exp 0", busy, fa_valid, fa_last, done));
  endtask

  task automatic t_small_table();
    tb_ncols = 5; tb_ntop = 2; tb_nbot = 1;
    tb_tab[0] = 0; tb_tab[1] = 2; tb_tab[2] = 4; tb_tab[3] = 5; tb_tab[4] = 7;
    load_table();
    run_walk("small", 1'b0, 1'b0, 840, 456, 384);
  endtask

  task automatic t_stall_and_pokes();
    // R6 under back-pressure, R9 restart and R10 write attempted mid-walk
    run_walk("stall_poke", 1'b1, 1'b1, 840, 456, 384);
  endtask

  task automatic t_table_kept();
    // R10: the mid-walk write to entry 0 must not have landed
    run_walk("table_kept", 1'b0, 1'b0, 840, 456, 384);
  endtask

  task automatic t_wide_table();
    // R10: idle rewrite takes effect; two RAM-type columns (codes 2 and 3)
    tb_ncols = 9; tb_ntop = 2; tb_nbot = 2;
    tb_tab[0] = 5; tb_tab[1] = 0; tb_tab[2] = 2; tb_tab[3] = 1; tb_tab[4] = 4;
    tb_tab[5] = 5; tb_tab[6] = 7; tb_tab[7] = 3; tb_tab[8] = 6;
    load_table();
    run_walk("wide", 1'b1, 1'b0, 2240, 1216, 1024);
  endtask

  task automatic t_no_ram();
    // R4: no RAM-type column, so the RAM-content area is skipped
    tb_ncols = 3; tb_ntop = 1; tb_nbot = 1;
    tb_tab[0] = 0; tb_tab[1] = 4; tb_tab[2] = 7;
    load_table();
    run_walk("no_ram", 1'b0, 1'b0, 136, 136, 0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_reset();
    t_small_table();
    t_stall_and_pokes();
    t_table_kept();
    t_wide_table();
    t_no_ram();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule